// File: doc/BRIEF.md
# Addressed Multidrop Packet Handler

This block is the protocol layer of a node on a shared multidrop serial bus. It sits behind a byte-stuffing frame decoder, which hands it one strobe per completed frame together with the decoded payload length and the first four payload bytes. The handler sorts each frame into one of five kinds by its length alone: discovery, command, address, bulk data half, or invalid.

A node has to be selected by an address frame carrying its 32-bit identifier before it acts on a command or a bulk data half. That selection is one-shot. Any command frame and any accepted data half drop the node back to the unselected state, and so does every invalid frame. A discovery frame asks for the node identifier, and it is answered only during a short window after boot. The window is timed from a millisecond tick.

The handler does not form any reply bytes. It raises a one-cycle request to send the identifier or a status reply, and it drops that request if the transmitter reports busy in that cycle. It keeps a saturating count of invalid frames. Every frame produces an activity pulse, and every invalid frame produces an error pulse.

Top module: `pkt_node_handler`

## Requirements
- R1: After reset the node is unselected (`nodeAddressed`=0), `invalidCount` is 0 and all pulse outputs are low.
- R2: Every `frameDone` strobe gives `actPulse`=1 in the following cycle, whatever the frame kind. `actPulse` is low in every other cycle.
- R3: A frame of length 0 (discovery) gives `reqIdTx`=1 in the next cycle only if fewer than `BOOT_MS` pulses of `msTick` have been seen since reset. It leaves the selection state unchanged and does not count as invalid.
- R4: A frame of length 4 selects the node when `frameHead` equals `nodeId`, and deselects it otherwise. Payload byte 0 sits in `frameHead[7:0]`. This frame is never counted as invalid.
- R5: A frame of length 1 received while selected gives `reqStatusTx`=1 in the next cycle when its code byte (`frameHead[7:0]`) is 0x01. Any other code gives no request. In both cases the node becomes unselected.
- R6: A frame of length 1 received while unselected increments `invalidCount`, pulses `errPulse` and gives no reply request.
- R7: A frame of length `HALF_LEN` received while selected pulses `dataHalfOk` and deselects the node. Received while unselected, it has no effect apart from `actPulse`: no error is flagged and nothing is counted.
- R8: A frame of any other length increments `invalidCount`, pulses `errPulse` and deselects the node.
- R9: A reply request (`reqIdTx` or `reqStatusTx`) is dropped, and not raised later, when `txBusy` is high in the cycle of the `frameDone` strobe. The two requests are never high together.
- R10: `invalidCount` saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameDone | input | 1 | One-cycle strobe: a decoded frame is complete |
| frameLen | input | LEN_W | Decoded payload length of the frame |
| frameHead | input | 32 | First four payload bytes, byte 0 in bits 7:0 |
| nodeId | input | 32 | Identifier of this node |
| msTick | input | 1 | One-cycle pulse per millisecond |
| txBusy | input | 1 | Transmitter busy; requests are dropped while high |
| nodeAddressed | output | 1 | Node is currently selected |
| reqIdTx | output | 1 | Pulse: send the node identifier |
| reqStatusTx | output | 1 | Pulse: send a status reply |
| dataHalfOk | output | 1 | Pulse: a data half was accepted |
| errPulse | output | 1 | Pulse: an invalid frame was seen |
| actPulse | output | 1 | Pulse: a frame was seen |
| invalidCount | output | CNT_W | Saturating count of invalid frames |

## Verification
The bench targets the points where a design could easily confuse the frame kinds. A discovery frame must leave the selection intact; a design that cleared it would refuse the command that follows. A data half received while unselected must not count as an error; a design that lumped it with unknown lengths would raise `errPulse`. The boot window edge is tested at exactly `BOOT_MS-1` and `BOOT_MS` ticks, so an off-by-one comparison answers one discovery too many or too few. Requests with `txBusy` high, a wrong identifier after a right one, non-status codes and counter saturation are covered as well: a leaked request, a sticky selection or a wrapping counter each shows up as a mismatch.

// File: rtl/pkt_node_pkg.sv
package pkt_node_pkg;

  typedef enum logic [2:0] {
    FK_DISCOVER = 3'd0,
    FK_COMMAND  = 3'd1,
    FK_SELECT   = 3'd2,
    FK_BULK     = 3'd3,
    FK_BAD      = 3'd4
  } frameKind_t;

  typedef struct packed {
    logic countInvalid;
    logic frameSeen;
  } ctrlStrobe_t;

  localparam logic [7:0] CMD_STATUS = 8'h01;

endpackage

// File: rtl/pkt_node_dp.sv
module pkt_node_dp
  import pkt_node_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int HALF_LEN = 96,
  parameter int BOOT_MS  = 100,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [31:0]       frameHead,
  input  logic [31:0]       nodeId,
  input  logic              msTick,
  input  ctrlStrobe_t       strobe,
  output frameKind_t        kind,
  output logic              idMatch,
  output logic              cmdIsStatus,
  output logic              bootOpen,
  output logic [CNT_W-1:0]  invalidCount
);

  localparam int BOOT_W = $clog2(BOOT_MS + 1);
  localparam logic [BOOT_W-1:0] BOOT_LIMIT = BOOT_W'(BOOT_MS);
  localparam logic [LEN_W-1:0]  LEN_DISC = '0;
  localparam logic [LEN_W-1:0]  LEN_CMD  = LEN_W'(1);
  localparam logic [LEN_W-1:0]  LEN_SEL  = LEN_W'(4);
  localparam logic [LEN_W-1:0]  LEN_BULK = LEN_W'(HALF_LEN);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

  logic [BOOT_W-1:0] bootMs;

  // classification by decoded length only
  always_comb begin
    if (frameLen == LEN_DISC)       kind = FK_DISCOVER;
    else if (frameLen == LEN_CMD)   kind = FK_COMMAND;
    else if (frameLen == LEN_SEL)   kind = FK_SELECT;
    else if (frameLen == LEN_BULK)  kind = FK_BULK;
    else                            kind = FK_BAD;
  end

  // byte-wise identifier compare, byte 0 least significant
  logic [3:0] byteEq;
  for (genvar b = 0; b < 4; b++) begin : g_idByte
    assign byteEq[b] = (frameHead[8*b +: 8] == nodeId[8*b +: 8]);
  end
  assign idMatch     = &byteEq;
  assign cmdIsStatus = (frameHead[7:0] == CMD_STATUS);

  // boot window timer, saturating at the limit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bootMs <= '0;
    end else if (msTick && (bootMs < BOOT_LIMIT)) begin
      bootMs <= bootMs + 1'b1;
    end
  end
  assign bootOpen = (bootMs < BOOT_LIMIT);

  // saturating invalid-frame counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      invalidCount <= '0;
    end else if (strobe.countInvalid && (invalidCount != CNT_MAX)) begin
      invalidCount <= invalidCount + 1'b1;
    end
  end

endmodule

// File: rtl/pkt_node_ctrl.sv
module pkt_node_ctrl
  import pkt_node_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameDone,
  input  frameKind_t  kind,
  input  logic        idMatch,
  input  logic        cmdIsStatus,
  input  logic        bootOpen,
  input  logic        txBusy,
  output ctrlStrobe_t strobe,
  output logic        nodeAddressed,
  output logic        reqIdTx,
  output logic        reqStatusTx,
  output logic        dataHalfOk,
  output logic        errPulse,
  output logic        actPulse
);

  typedef enum logic {ST_IGNORE = 1'b0, ST_ADDRESSED = 1'b1} protoState_t;

  protoState_t stateQ, stateD;
  logic idReqD, statReqD, bulkOkD, errD;

  always_comb begin
    stateD   = stateQ;
    idReqD   = 1'b0;
    statReqD = 1'b0;
    bulkOkD  = 1'b0;
    errD     = 1'b0;
    if (frameDone) begin
      unique case (kind)
        FK_DISCOVER: begin
          idReqD = bootOpen && !txBusy;
        end
        FK_COMMAND: begin
          if (stateQ == ST_ADDRESSED) begin
            statReqD = cmdIsStatus && !txBusy;
          end else begin
            errD = 1'b1;
          end
          stateD = ST_IGNORE;
        end
        FK_SELECT: begin
          stateD = idMatch ? ST_ADDRESSED : ST_IGNORE;
        end
        FK_BULK: begin
          bulkOkD = (stateQ == ST_ADDRESSED);
          stateD  = ST_IGNORE;
        end
        default: begin
          errD   = 1'b1;
          stateD = ST_IGNORE;
        end
      endcase
    end
  end

  always_comb begin
    strobe.countInvalid = errD;
    strobe.frameSeen    = frameDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= ST_IGNORE;
      reqIdTx     <= 1'b0;
      reqStatusTx <= 1'b0;
      dataHalfOk  <= 1'b0;
      errPulse    <= 1'b0;
      actPulse    <= 1'b0;
    end else begin
      stateQ      <= stateD;
      reqIdTx     <= idReqD;
      reqStatusTx <= statReqD;
      dataHalfOk  <= bulkOkD;
      errPulse    <= errD;
      actPulse    <= strobe.frameSeen;
    end
  end

  assign nodeAddressed = (stateQ == ST_ADDRESSED);

endmodule

// File: rtl/pkt_node_handler.sv
module pkt_node_handler
  import pkt_node_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int HALF_LEN = 96,
  parameter int BOOT_MS  = 100,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameDone,
  input  logic [LEN_W-1:0] frameLen,
  input  logic [31:0]      frameHead,
  input  logic [31:0]      nodeId,
  input  logic             msTick,
  input  logic             txBusy,
  output logic             nodeAddressed,
  output logic             reqIdTx,
  output logic             reqStatusTx,
  output logic             dataHalfOk,
  output logic             errPulse,
  output logic             actPulse,
  output logic [CNT_W-1:0] invalidCount
);

  frameKind_t  kind;
  ctrlStrobe_t strobe;
  logic        idMatch;
  logic        cmdIsStatus;
  logic        bootOpen;

  pkt_node_dp #(
    .LEN_W(LEN_W), .HALF_LEN(HALF_LEN), .BOOT_MS(BOOT_MS), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .frameLen(frameLen), .frameHead(frameHead),
    .nodeId(nodeId), .msTick(msTick), .strobe(strobe), .kind(kind),
    .idMatch(idMatch), .cmdIsStatus(cmdIsStatus), .bootOpen(bootOpen),
    .invalidCount(invalidCount)
  );

  pkt_node_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .kind(kind),
    .idMatch(idMatch), .cmdIsStatus(cmdIsStatus), .bootOpen(bootOpen),
    .txBusy(txBusy), .strobe(strobe), .nodeAddressed(nodeAddressed),
    .reqIdTx(reqIdTx), .reqStatusTx(reqStatusTx), .dataHalfOk(dataHalfOk),
    .errPulse(errPulse), .actPulse(actPulse)
  );

endmodule

// File: rtl/pkt_node_handler_chk.sv
module pkt_node_handler_chk #(
  parameter int LEN_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameDone,
  input logic [LEN_W-1:0] frameLen,
  input logic [31:0]      frameHead,
  input logic [31:0]      nodeId,
  input logic             txBusy,
  input logic             nodeAddressed,
  input logic             reqIdTx,
  input logic             reqStatusTx,
  input logic             errPulse,
  input logic             actPulse,
  input logic [CNT_W-1:0] invalidCount
);

  p_act_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> actPulse);

  p_act_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    actPulse |-> $past(frameDone));

  p_select_r4: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && frameLen == LEN_W'(4) && frameHead == nodeId) |=> nodeAddressed);

  p_cmd_oneshot_r5: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && frameLen == LEN_W'(1)) |=> !nodeAddressed);

  p_err_deselect_r8: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !nodeAddressed);

  p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && txBusy) |=> (!reqIdTx && !reqStatusTx));

  p_one_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqIdTx, reqStatusTx}));

  p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(invalidCount) == '1) |-> (invalidCount == '1));

endmodule

bind pkt_node_handler pkt_node_handler_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .frameDone(frameDone), .frameLen(frameLen),
  .frameHead(frameHead), .nodeId(nodeId), .txBusy(txBusy),
  .nodeAddressed(nodeAddressed), .reqIdTx(reqIdTx), .reqStatusTx(reqStatusTx),
  .errPulse(errPulse), .actPulse(actPulse), .invalidCount(invalidCount)
);

// File: tb/test_pkt_node_handler.sv
module test_pkt_node_handler;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W    = 8;
  localparam int HALF_LEN = 96;
  localparam int BOOT_MS  = 100;
  localparam int CNT_W    = 4;
  localparam logic [31:0] MY_ID = 32'hC0DE_5A17;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameDone = 1'b0;
  logic [LEN_W-1:0] frameLen = '0;
  logic [31:0] frameHead = '0;
  logic [31:0] nodeId = MY_ID;
  logic msTick = 1'b0;
  logic txBusy = 1'b0;
  logic nodeAddressed, reqIdTx, reqStatusTx, dataHalfOk, errPulse, actPulse;
  logic [CNT_W-1:0] invalidCount;

  int compared = 0;
  int mismatched = 0;

  // bench model state
  logic mAddr = 1'b0;
  int   mBoot = 0;
  int   mCnt  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_node_handler #(
    .LEN_W(LEN_W), .HALF_LEN(HALF_LEN), .BOOT_MS(BOOT_MS), .CNT_W(CNT_W)
  ) i_pkt_node_handler (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .frameLen(frameLen),
    .frameHead(frameHead), .nodeId(nodeId), .msTick(msTick), .txBusy(txBusy),
    .nodeAddressed(nodeAddressed), .reqIdTx(reqIdTx), .reqStatusTx(reqStatusTx),
    .dataHalfOk(dataHalfOk), .errPulse(errPulse), .actPulse(actPulse),
    .invalidCount(invalidCount)
  );

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int satInc(int c);
    return (c >= (1 << CNT_W) - 1) ? c : c + 1;
  endfunction

  task automatic tickMs(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); msTick = 1'b1;
      @(negedge clk); msTick = 1'b0;
      if (mBoot < BOOT_MS) mBoot++;
    end
  endtask

  // drive one frame, update the model, check every output one cycle later
  task automatic sendFrame(int len, logic [31:0] head, logic busy, string tag);
    int eId = 0, eSt = 0, eOk = 0, eErr = 0;
    @(negedge clk);
    frameDone = 1'b1; frameLen = LEN_W'(len); frameHead = head; txBusy = busy;
    if (len == 0) begin
      eId = (mBoot < BOOT_MS && !busy) ? 1 : 0;
    end else if (len == 1) begin
      if (mAddr) eSt = (head[7:0] == 8'h01 && !busy) ? 1 : 0;
      else begin eErr = 1; mCnt = satInc(mCnt); end
      mAddr = 1'b0;
    end else if (len == 4) begin
      mAddr = (head == MY_ID);
    end else if (len == HALF_LEN) begin
      eOk = mAddr ? 1 : 0;
      mAddr = 1'b0;
    end else begin
      eErr = 1; mCnt = satInc(mCnt); mAddr = 1'b0;
    end
    @(negedge clk);
    frameDone = 1'b0; txBusy = 1'b0;
    check("R2", {tag, " actPulse"}, int'(actPulse), 1);
    check(busy ? "R9" : "R3", {tag, " reqIdTx"}, int'(reqIdTx), eId);
    check(busy ? "R9" : "R5", {tag, " reqStatusTx"}, int'(reqStatusTx), eSt);
    check("R4", {tag, " nodeAddressed"}, int'(nodeAddressed), int'(mAddr));
    check("R7", {tag, " dataHalfOk"}, int'(dataHalfOk), eOk);
    check(len == 1 ? "R6" : "R8", {tag, " errPulse"}, int'(errPulse), eErr);
    check(len == 1 ? "R6" : "R8", {tag, " invalidCount"}, int'(invalidCount), mCnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "nodeAddressed", int'(nodeAddressed), 0);
    check("R1", "invalidCount", int'(invalidCount), 0);
    check("R1", "pulses", int'({reqIdTx, reqStatusTx, dataHalfOk, errPulse, actPulse}), 0);
    @(negedge clk);
    check("R2", "actPulse idle", int'(actPulse), 0);

    // R3 discovery inside window, busy drop R9
    sendFrame(0, 32'h0, 1'b0, "disc-early");
    sendFrame(0, 32'h0, 1'b1, "disc-busy");
    check("R9", "no late reqIdTx", int'(reqIdTx), 0);

    // R4/R5 select, discovery keeps selection, status command
    sendFrame(4, MY_ID, 1'b0, "select");
    sendFrame(0, 32'h0, 1'b0, "disc-selected");
    sendFrame(1, 32'h0000_0001, 1'b0, "status");
    sendFrame(1, 32'h0000_0001, 1'b0, "cmd-unselected");   // R6
    sendFrame(4, MY_ID, 1'b0, "select2");
    sendFrame(1, 32'h0000_0007, 1'b0, "other-code");       // R5
    sendFrame(4, MY_ID, 1'b0, "select3");
    sendFrame(1, 32'h0000_0001, 1'b1, "status-busy");      // R9
    // byte order: swapped id must not match
    sendFrame(4, {MY_ID[7:0], MY_ID[15:8], MY_ID[23:16], MY_ID[31:24]}, 1'b0, "id-swapped");
    sendFrame(4, MY_ID, 1'b0, "select4");
    sendFrame(4, MY_ID ^ 32'h0100_0000, 1'b0, "wrong-id");
    // R7 data halves
    sendFrame(HALF_LEN, 32'h0, 1'b0, "bulk-unselected");
    sendFrame(4, MY_ID, 1'b0, "select5");
    sendFrame(HALF_LEN, 32'h0, 1'b0, "bulk-selected");
    sendFrame(HALF_LEN, 32'h0, 1'b0, "bulk-again");
    // R8 other lengths
    sendFrame(4, MY_ID, 1'b0, "select6");
    sendFrame(2, 32'h0, 1'b0, "len2");
    sendFrame(HALF_LEN + 1, 32'h0, 1'b0, "len-half-plus1");

    // R3 window edges
    tickMs(BOOT_MS - 1);
    sendFrame(0, 32'h0, 1'b0, "disc-last-ms");
    tickMs(1);
    sendFrame(0, 32'h0, 1'b0, "disc-closed");
    tickMs(3);
    sendFrame(0, 32'h0, 1'b0, "disc-closed-sat");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 9);
      int len;
      logic [31:0] head;
      logic busy;
      case (sel)
        0: len = 0;
        1, 2: len = 1;
        3, 4, 5: len = 4;
        6, 7: len = HALF_LEN;
        default: len = $urandom_range(0, 255);
      endcase
      head = ($urandom_range(0, 2) != 0) ? MY_ID : $urandom;
      if (len == 1 && $urandom_range(0, 1) == 1) head = 32'h0000_0001;
      busy = ($urandom_range(0, 4) == 0);
      sendFrame(len, head, busy, "rand");
    end

    // R10 saturation, counter is CNT_W bits wide
    for (int i = 0; i < 20; i++) sendFrame(3, 32'h0, 1'b0, "sat");
    check("R10", "invalidCount saturated", int'(invalidCount), (1 << CNT_W) - 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule